// File: doc/BRIEF.md
# Bit-Oriented Frame Receiver

This block receives a bit-oriented, flag-delimited serial link in the HDLC family. Each rising edge of its clock is one bit-time, and the serial input is sampled on that edge. While idle the receiver hunts for the flag pattern. Once it has found a flag it removes the zero bits the transmitter inserted, assembles bytes least significant bit first and runs a CRC-16 over every byte of the frame. Marking runs on the line (abort) send it back to hunting.

Every assembled byte, including the two check-sequence bytes at the end of the frame, goes into a small byte buffer. Each entry carries status bits. The closing flag tags the final byte with end-of-frame and the CRC verdict. When an end-of-frame or overrun byte is read out, the buffer locks and raises a special condition. It stays locked until an error-reset command. A two-bit mode input chooses how the block asks for service. It can raise an interrupt for every byte, for the first byte only (later bytes then raise data requests), for special conditions only (every byte raises a data request), or never (polling).

Top module: `hdlc_frame_rx`

## Requirements
- R1: After reset the receiver is hunting (`hunt`=1), the buffer is empty and unlocked, and `irq`, `dreq`, `sync_pulse` and `ext_evt` are 0.
- R2: A flag (a 0, six 1s, a 0) received while hunting clears `hunt`. In the same cycle as the sync pulse, it also pulses `ext_evt` for one clock.
- R3: `sync_pulse` is high for exactly one bit-time: the bit-time that follows the edge that samples the last bit of any flag.
- R4: After five consecutive 1s inside a frame, the next 0 is deleted. Data bytes such as 0xFF, 0x7E and 0x3F come out unchanged.
- R5: The bytes come out in arrival order, each assembled LSB first. A frame of N data bytes delivers N+2 bytes: the two check-sequence bytes follow the data as ordinary bytes, low byte first.
- R6: The CRC is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, and it is restarted at every flag. When the closing flag arrives, the last byte of the frame is tagged `byte_eof`=1. That byte also gets `byte_crc_err`=1 if the residue over data and check bytes is not 0xF0B8, or if the frame did not end on a byte boundary. No other byte is tagged end-of-frame.
- R7: Reading out a byte tagged end-of-frame sets `locked`. While locked, `byte_valid` and `dreq` stay 0 even if new bytes arrive. `err_reset` unlocks the buffer, and the stored bytes are then delivered.
- R8: Seven or more consecutive 1s abort. While in sync this sets `hunt` and pulses `ext_evt`. A partial byte in progress is discarded.
- R9: Mode 2'b10: `irq` is high whenever a byte can be read; `dreq` stays 0.
- R10: Mode 2'b01: `irq` is raised for the first byte read after `arm_next` (or after reset), and that read disarms it. Later bytes raise `dreq` instead, until `arm_next` re-arms the interrupt.
- R11: Mode 2'b11: `dreq` is high whenever a byte can be read, and no per-byte interrupt is raised. Once a special-condition byte has been read, `irq` stays high until `err_reset`.
- R12: Mode 2'b00: `irq` and `dreq` stay 0 at all times, but bytes can still be read and locking still works.
- R13: A byte that completes while the buffer holds DEPTH entries is dropped. The next stored byte carries `byte_ovr`=1. The special condition (lock) is raised only when that byte is read, not when the drop happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one bit-time per rising edge |
| rst_n | input | 1 | Active-low reset |
| rxd | input | 1 | Serial data input |
| int_mode | input | 2 | Service mode: 00 none, 01 first byte, 10 every byte, 11 special only |
| rd | input | 1 | Read strobe; pops the head byte when `byte_valid` is 1 |
| err_reset | input | 1 | Unlock command; clears the special condition |
| arm_next | input | 1 | Re-arms the first-byte interrupt |
| rx_byte | output | 8 | Head byte of the buffer |
| byte_valid | output | 1 | Head byte present and buffer not locked |
| byte_eof | output | 1 | Head byte is the last byte of a frame |
| byte_crc_err | output | 1 | CRC or alignment failure, valid with `byte_eof` |
| byte_ovr | output | 1 | At least one byte was dropped before this one |
| hunt | output | 1 | Receiver is hunting for a flag |
| sync_pulse | output | 1 | One bit-time pulse after each flag |
| ext_evt | output | 1 | One-clock pulse on every hunt/sync change |
| irq | output | 1 | Interrupt request |
| dreq | output | 1 | Data transfer request |
| locked | output | 1 | Buffer is locked after a special condition |

## Verification
The bench builds the block with the default DEPTH of 4. With that depth, an unread frame of three data bytes (five buffered bytes) is enough to force a drop and to show the overrun flag moving onto the next stored byte. Random frames of up to ten data bytes run longer than the buffer, so they are drained while they arrive. That exercises simultaneous push and pop, and carries stuffed patterns through the whole path.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD = 16'hF0B8;
    localparam logic [15:0] CRC_POLY = 16'h8408;

    typedef struct packed {
        logic [7:0] data;
        logic       eof;
        logic       crc_err;
        logic       ovr;
    } entry_t;

    // byte-wide update of the reflected CRC-16, LSB first
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_rx_bitproc.sv
module hdlc_rx_bitproc
    import hdlc_rx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rxd,
    output logic   push,
    output entry_t push_e,
    output logic   hunt,
    output logic   sync_pulse,
    output logic   ext_evt
);
    typedef struct packed {
        logic [2:0]  ones;
        logic        hunt;
        logic [7:0]  shift;
        logic [2:0]  bcnt;
        logic [7:0]  hold;
        logic        hold_vld;
        logic [15:0] crc;
        logic        sync;
        logic        ext;
        logic        push;
        entry_t      push_e;
    } st_t;

    st_t q, n;
    logic       do_bit, bval;
    logic [7:0] byte_w;

    always_comb begin
        n        = q;
        n.sync   = 1'b0;
        n.ext    = 1'b0;
        n.push   = 1'b0;
        n.push_e = '0;
        do_bit   = 1'b0;
        bval     = 1'b0;
        byte_w   = {rxd, q.shift[7:1]};
        if (rxd) begin
            n.ones = (q.ones == 3'd7) ? 3'd7 : q.ones + 3'd1;
            if (q.ones == 3'd6) begin
                // seventh one in a row: abort
                if (!q.hunt) n.ext = 1'b1;
                n.hunt     = 1'b1;
                n.hold_vld = 1'b0;
                n.bcnt     = '0;
                n.crc      = CRC_INIT;
            end else if (q.ones < 3'd5 && !q.hunt) begin
                do_bit = 1'b1;
                bval   = 1'b1;
            end
        end else begin
            n.ones = '0;
            if (q.ones == 3'd6) begin
                // flag found
                n.sync = 1'b1;
                if (q.hunt) begin
                    n.hunt = 1'b0;
                    n.ext  = 1'b1;
                end else if (q.hold_vld) begin
                    n.push           = 1'b1;
                    n.push_e.data    = q.hold;
                    n.push_e.eof     = 1'b1;
                    n.push_e.crc_err = (q.crc != CRC_GOOD) || (q.bcnt != 3'd6);
                end
                n.hold_vld = 1'b0;
                n.bcnt     = '0;
                n.crc      = CRC_INIT;
            end else if (q.ones != 3'd5 && q.ones != 3'd7 && !q.hunt) begin
                do_bit = 1'b1;
                bval   = 1'b0;
            end
        end
        if (do_bit) begin
            byte_w  = {bval, q.shift[7:1]};
            n.shift = byte_w;
            n.bcnt  = q.bcnt + 3'd1;
            if (q.bcnt == 3'd7) begin
                if (q.hold_vld) begin
                    n.push        = 1'b1;
                    n.push_e.data = q.hold;
                end
                n.hold     = byte_w;
                n.hold_vld = 1'b1;
                n.crc      = crc_byte(q.crc, byte_w);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.hunt <= 1'b1;
            q.ones <= 3'd7;
            q.crc  <= CRC_INIT;
        end else begin
            q <= n;
        end
    end

    assign push       = q.push;
    assign push_e     = q.push_e;
    assign hunt       = q.hunt;
    assign sync_pulse = q.sync;
    assign ext_evt    = q.ext;

    p_sync_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.sync |=> !q.sync);
    p_ext_on_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hunt != $past(q.hunt)) |-> q.ext);
    p_hunt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hunt && $past(q.hunt)) |-> !q.push);

endmodule

// File: rtl/hdlc_rx_buf.sv
module hdlc_rx_buf
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  entry_t     push_e,
    input  logic [1:0] int_mode,
    input  logic       rd,
    input  logic       err_reset,
    input  logic       arm_next,
    output entry_t     head,
    output logic       byte_valid,
    output logic       irq,
    output logic       dreq,
    output logic       locked
);
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]      rptr;
        logic [AW-1:0]      wptr;
        logic [CW-1:0]      cnt;
        logic               ovr_pend;
        logic               lock;
        logic               special;
        logic               armed;
    } st_t;

    st_t    q, n;
    logic   pop, acc;
    entry_t e;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign head       = q.mem[q.rptr];
    assign byte_valid = (q.cnt != '0) && !q.lock;
    assign pop        = rd && byte_valid;

    always_comb begin
        n   = q;
        acc = 1'b0;
        e   = push_e;
        if (pop) begin
            n.rptr  = nxt(q.rptr);
            n.armed = 1'b0;
            if (head.eof || head.ovr) begin
                n.lock    = 1'b1;
                n.special = 1'b1;
            end
        end
        if (push) begin
            if (q.cnt == CW'(DEPTH) && !pop) begin
                n.ovr_pend = 1'b1;
            end else begin
                acc            = 1'b1;
                e.ovr          = push_e.ovr | q.ovr_pend;
                n.mem[q.wptr]  = e;
                n.ovr_pend     = 1'b0;
                n.wptr         = nxt(q.wptr);
            end
        end
        if (acc && !pop)      n.cnt = q.cnt + CW'(1);
        else if (!acc && pop) n.cnt = q.cnt - CW'(1);
        if (err_reset) begin
            n.lock    = 1'b0;
            n.special = 1'b0;
        end
        if (arm_next) n.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.armed <= 1'b1;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        irq  = 1'b0;
        dreq = 1'b0;
        unique case (int_mode)
            2'b01: begin
                irq  = q.special || (q.armed && byte_valid);
                dreq = !q.armed && byte_valid;
            end
            2'b10: irq = q.special || byte_valid;
            2'b11: begin
                irq  = q.special;
                dreq = byte_valid;
            end
            default: ;
        endcase
    end

    assign locked = q.lock;

    p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    p_lock_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lock && !err_reset) |=> q.lock);
    p_first_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !arm_next) |=> !q.armed);

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic [1:0] int_mode,
    input  logic       rd,
    input  logic       err_reset,
    input  logic       arm_next,
    output logic [7:0] rx_byte,
    output logic       byte_valid,
    output logic       byte_eof,
    output logic       byte_crc_err,
    output logic       byte_ovr,
    output logic       hunt,
    output logic       sync_pulse,
    output logic       ext_evt,
    output logic       irq,
    output logic       dreq,
    output logic       locked
);
    logic   push;
    entry_t push_e;
    entry_t head;

    hdlc_rx_bitproc u_bit (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (rxd),
        .push       (push),
        .push_e     (push_e),
        .hunt       (hunt),
        .sync_pulse (sync_pulse),
        .ext_evt    (ext_evt)
    );

    hdlc_rx_buf #(.DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_e     (push_e),
        .int_mode   (int_mode),
        .rd         (rd),
        .err_reset  (err_reset),
        .arm_next   (arm_next),
        .head       (head),
        .byte_valid (byte_valid),
        .irq        (irq),
        .dreq       (dreq),
        .locked     (locked)
    );

    assign rx_byte      = head.data;
    assign byte_eof     = head.eof;
    assign byte_crc_err = head.crc_err;
    assign byte_ovr     = head.ovr;

    p_mode0_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode == 2'b00) |-> (!irq && !dreq));

endmodule

// File: tb/sim_hdlc_frame_rx.sv
module sim_hdlc_frame_rx;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] int_mode = 2'b11;
    logic       rd = 1'b0, err_reset = 1'b0, arm_next = 1'b0;
    logic [7:0] rx_byte;
    logic       byte_valid, byte_eof, byte_crc_err, byte_ovr;
    logic       hunt, sync_pulse, ext_evt, irq, dreq, locked;

    int nchk = 0, nfail = 0;
    logic [7:0] fr [16];
    int         flen;
    logic [15:0] sent_fcs;
    logic [7:0] gdat [32];
    logic       geof [32];
    logic       gcrc [32];
    logic       govr [32];
    int         gn;

    always #(CLK_NS/2) clk = ~clk;

    hdlc_frame_rx u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .int_mode(int_mode), .rd(rd),
        .err_reset(err_reset), .arm_next(arm_next), .rx_byte(rx_byte),
        .byte_valid(byte_valid), .byte_eof(byte_eof), .byte_crc_err(byte_crc_err),
        .byte_ovr(byte_ovr), .hunt(hunt), .sync_pulse(sync_pulse), .ext_evt(ext_evt),
        .irq(irq), .dreq(dreq), .locked(locked)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fcs_of(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ fr[i][k]) c = (c >> 1) ^ 16'h8408;
                else                 c = c >> 1;
            end
        return ~c;
    endfunction

    task automatic bitout(input logic b);
        rxd = b;
        @(negedge clk);
    endtask

    task automatic send_flag();
        bitout(1'b0);
        for (int i = 0; i < 6; i++) bitout(1'b1);
        bitout(1'b0);
    endtask

    task automatic send_stuffed(input logic [7:0] v, inout int ones);
        for (int i = 0; i < 8; i++) begin
            bitout(v[i]);
            if (v[i]) ones++; else ones = 0;
            if (ones == 5) begin
                bitout(1'b0);
                ones = 0;
            end
        end
    endtask

    task automatic send_frame(input bit corrupt);
        int ones = 0;
        sent_fcs = fcs_of(flen) ^ (corrupt ? 16'h0001 : 16'h0000);
        send_flag();
        for (int i = 0; i < flen; i++) send_stuffed(fr[i], ones);
        send_stuffed(sent_fcs[7:0], ones);
        send_stuffed(sent_fcs[15:8], ones);
        send_flag();
        for (int i = 0; i < 12; i++) bitout(1'b1);
    endtask

    task automatic drain(input int maxb);
        bit done = 0;
        gn = 0;
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            rd = 1'b0;
            if (done) break;
            if (byte_valid) begin
                if (gn < 32) begin
                    gdat[gn] = rx_byte; geof[gn] = byte_eof;
                    gcrc[gn] = byte_crc_err; govr[gn] = byte_ovr;
                end
                gn++;
                rd = 1'b1;
                if (byte_eof || gn >= maxb) done = 1;
            end
        end
        rd = 1'b0;
    endtask

    task automatic check_frame(input string req, input bit bad);
        logic [7:0] e;
        chk(gn == flen + 2, {req, " byte count"}, gn, flen + 2);
        for (int i = 0; i < gn && i < 32 && i < flen + 2; i++) begin
            e = (i < flen) ? fr[i] : (i == flen) ? sent_fcs[7:0] : sent_fcs[15:8];
            chk(gdat[i] == e, {req, " data"}, gdat[i], e);
            chk(geof[i] == (i == flen + 1), "R6 eof tag", geof[i], i == flen + 1);
            if (i == flen + 1) chk(gcrc[i] == bad, "R6 crc verdict", gcrc[i], bad);
        end
    endtask

    task automatic pulse_err();
        err_reset = 1'b1;
        @(negedge clk);
        err_reset = 1'b0;
    endtask

    task automatic pulse_arm();
        arm_next = 1'b1;
        @(negedge clk);
        arm_next = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(hunt == 1, "R1 hunt", hunt, 1);
        chk(!byte_valid && !locked, "R1 buffer", {byte_valid, locked}, 0);
        chk(!irq && !dreq && !sync_pulse && !ext_evt, "R1 requests", {irq, dreq, sync_pulse, ext_evt}, 0);

        // R2 R3 flag from hunt
        for (int i = 0; i < 10; i++) bitout(1'b1);
        bitout(1'b0);
        for (int i = 0; i < 6; i++) bitout(1'b1);
        chk(sync_pulse == 0, "R3 no early pulse", sync_pulse, 0);
        bitout(1'b0);
        chk(sync_pulse == 1, "R3 pulse after flag", sync_pulse, 1);
        chk(hunt == 0, "R2 hunt cleared", hunt, 0);
        chk(ext_evt == 1, "R2 ext event", ext_evt, 1);
        bitout(1'b1);
        chk(sync_pulse == 0, "R3 single bit-time", sync_pulse, 0);
        chk(ext_evt == 0, "R2 ext single", ext_evt, 0);

        // R8 abort: 7 ones in total after the flag
        for (int i = 0; i < 6; i++) bitout(1'b1);
        chk(hunt == 1 && ext_evt == 1, "R8 abort", {hunt, ext_evt}, 3);
        bitout(1'b1);

        // R4 R5 R6 R11 stuffing-heavy frame, mode 11
        int_mode = 2'b11;
        flen = 2; fr[0] = 8'h7E; fr[1] = 8'h3F;
        send_frame(0);
        chk(dreq == 1 && irq == 0, "R11 dreq no irq", {dreq, irq}, 2);
        drain(16);
        check_frame("R4", 0);
        chk(irq == 1 && locked == 1, "R11 special irq", {irq, locked}, 3);

        // R7 locked buffer
        flen = 1; fr[0] = 8'h55;
        send_frame(0);
        chk(!byte_valid && !dreq, "R7 locked quiet", {byte_valid, dreq}, 0);
        pulse_err();
        chk(irq == 0 && byte_valid == 1, "R7 unlocked", {irq, byte_valid}, 1);
        drain(16);
        check_frame("R7", 0);
        pulse_err();

        // R5 frame longer than buffer, drained concurrently
        flen = 4; fr[0] = 8'h81; fr[1] = 8'h42; fr[2] = 8'hFF; fr[3] = 8'h42;
        fork send_frame(0); drain(16); join
        check_frame("R5", 0);
        pulse_err();

        // R6 corrupted check sequence
        flen = 2; fr[0] = 8'hC3; fr[1] = 8'h01;
        send_frame(1);
        drain(16);
        check_frame("R6", 1);
        pulse_err();

        // R9 every-byte mode
        int_mode = 2'b10;
        flen = 1; fr[0] = 8'hA5;
        send_frame(0);
        chk(irq == 1 && dreq == 0, "R9 irq per byte", {irq, dreq}, 2);
        drain(16);
        check_frame("R9", 0);
        pulse_err();

        // R10 first-byte mode
        int_mode = 2'b01;
        pulse_arm();
        flen = 2; fr[0] = 8'h11; fr[1] = 8'h22;
        send_frame(0);
        chk(irq == 1 && dreq == 0, "R10 first irq", {irq, dreq}, 2);
        drain(1);
        chk(gdat[0] == 8'h11, "R10 first data", gdat[0], 8'h11);
        chk(irq == 0 && dreq == 1, "R10 then dreq", {irq, dreq}, 1);
        pulse_arm();
        chk(irq == 1 && dreq == 0, "R10 rearmed", {irq, dreq}, 2);
        drain(16);
        chk(gn == 3 && geof[2] == 1, "R10 rest", gn, 3);
        pulse_err();

        // R12 polling mode
        int_mode = 2'b00;
        flen = 1; fr[0] = 8'h33;
        send_frame(0);
        chk(irq == 0 && dreq == 0 && byte_valid == 1, "R12 silent", {irq, dreq, byte_valid}, 1);
        drain(16);
        check_frame("R12", 0);
        chk(irq == 0 && locked == 1, "R12 lock no irq", {irq, locked}, 1);
        pulse_err();

        // R13 overrun
        int_mode = 2'b11;
        flen = 3; fr[0] = 8'h01; fr[1] = 8'h02; fr[2] = 8'h03;
        send_frame(0);
        chk(locked == 0, "R13 no lock at drop", locked, 0);
        drain(4);
        chk(gn == 4, "R13 kept depth", gn, 4);
        for (int i = 0; i < 4; i++)
            chk(!govr[i] && !geof[i], "R13 early bytes clean", {govr[i], geof[i]}, 0);
        chk(locked == 0 && irq == 0, "R13 not signalled yet", {locked, irq}, 0);
        flen = 1; fr[0] = 8'h09;
        fork send_frame(0); drain(1); join
        chk(gdat[0] == 8'h09 && govr[0] == 1, "R13 ovr tag", {gdat[0], govr[0]}, 9'h013);
        chk(locked == 1 && irq == 1, "R13 special on read", {locked, irq}, 3);
        pulse_err();
        drain(16);
        chk(gn == 2 && geof[1] == 1, "R13 tail", gn, 2);
        pulse_err();

        // R5 R6 random frames
        for (int f = 0; f < 8; f++) begin
            flen = 1 + int'($urandom % 10);
            for (int i = 0; i < flen; i++) fr[i] = 8'($urandom);
            if (f == 0) for (int i = 0; i < flen; i++) fr[i] = 8'hFF;
            fork send_frame(0); drain(16); join
            check_frame("R5 random", 0);
            pulse_err();
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule